// File: doc/BRIEF.md
# Upper memory bank mapper

The block sits on the bus of a CPU with 16-bit addresses and 8-bit data. It decides where each bus cycle goes: a 64 KiB physical RAM, a 12 KiB upper ROM, one of two 4 KiB peripheral ROMs, or the I/O space. It produces registered chip selects, write enables and physical addresses for each of them. It then returns the read data of the chosen device to the CPU.

A small mode register lives inside the block. Any bus cycle, read or write, to one of sixteen switch addresses loads that register from the low four address bits. The register decides three things for the top 12 KiB of the address space: whether upper RAM takes writes, whether upper reads come from ROM or RAM, and which of two RAM banks backs the 4 KiB window just above the I/O page. Reads and writes to the same upper address can therefore reach different devices. The second bank of that window is stored in the physical RAM hole that the I/O and peripheral pages leave below it.

A bus request is a single cycle with `cpu_valid` high. The device strobes appear after the next clock edge. Read data and `cpu_rvalid` appear two edges after that, which leaves one clock for a synchronous memory read.

Top module: `upper_bank_mapper`

## Requirements
- R1: A bus cycle to 0x0000–0xBFFF selects RAM at the same physical address, for reads and for writes alike.
- R2: A cycle to 0xC000–0xC0FF outside the switch window selects the I/O space with address bits [7:0]. It asserts no memory select.
- R3: A read or a write to 0xC080–0xC08F loads the mode from address bits [3:0], and the new mode governs the next bus cycle. Such a cycle selects no device, and a read of it returns 0x00.
- R4: With mode bit 0 at 0, writes to 0xD000–0xFFFF assert no select, and physical RAM is left unchanged.
- R5: Reads of 0xD000–0xFFFF come from the upper ROM when mode bit 1 XOR mode bit 0 is 1, and from RAM otherwise.
- R6: With mode bit 3 at 0, the RAM behind 0xD000–0xDFFF is physical 0xD000–0xDFFF. With bit 3 at 1 it is physical 0xC000–0xCFFF. Mode bit 2 has no effect.
- R7: RAM behind 0xE000–0xFFFF is always at the same physical address, under the same write and read-source controls.
- R8: An upper ROM read uses ROM address (CPU address − 0xD000), whatever bank is chosen.
- R9: While reads come from ROM and RAM is writable, a write updates the selected RAM bank, and a later read of that address still returns the ROM byte.
- R10: Reads of 0xC100–0xCFFF select peripheral ROM 0 when `per_sel` is 0 and ROM 1 when it is 1, with address bits [11:0]. Writes there select nothing.
- R11: Reset leaves bank 0xD000, writable upper RAM and upper reads from ROM, so a read of 0xFFFC returns the ROM byte. All selects are low and `cpu_rvalid` is 0.
- R12: Device selects appear one edge after the request. `cpu_rdata` and `cpu_rvalid` appear three edges after it, and `cpu_rvalid` is high only for reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_valid | input | 1 | Bus cycle present this clock |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| per_sel | input | 1 | Peripheral ROM choice (0 or 1) |
| cpu_rdata | output | 8 | Read data back to the CPU |
| cpu_rvalid | output | 1 | `cpu_rdata` holds a read result |
| ram_cs | output | 1 | RAM select |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | 16 | Physical RAM address |
| mem_wdata | output | 8 | Write data to RAM and I/O |
| ram_rdata | input | 8 | RAM read data, one clock after select |
| urom_cs | output | 1 | Upper ROM select |
| urom_addr | output | 14 | Upper ROM address |
| urom_rdata | input | 8 | Upper ROM read data |
| per_cs | output | 2 | Peripheral ROM selects, bit n = ROM n |
| per_addr | output | 12 | Peripheral ROM address |
| per0_rdata | input | 8 | Peripheral ROM 0 read data |
| per1_rdata | input | 8 | Peripheral ROM 1 read data |
| io_cs | output | 1 | I/O space select |
| io_we | output | 1 | I/O write enable |
| io_addr | output | 8 | I/O register address |
| io_rdata | input | 8 | I/O read data |

## Verification
The bench builds the block with its default parameters. These give a 16-bit address, 8-bit data, a 14-bit upper ROM address, 12-bit peripheral ROM addresses and the switch window at 0xC080. With them, every one of the sixteen mode nibbles can be walked through. Both physical homes of the banked window (0xC000 and 0xD000 pages) can be inspected in a RAM model, and the ROM offset can be tested at its first and last byte. Each device model answers with a byte computed from its address, so a read steered to the wrong device shows up as a miscompare.

// File: rtl/ubm_pkg.sv
package ubm_pkg;

  // source of the byte returned to the CPU
  typedef enum logic [2:0] {
    SRC_NONE = 3'd0,
    SRC_RAM  = 3'd1,
    SRC_UROM = 3'd2,
    SRC_PER0 = 3'd3,
    SRC_PER1 = 3'd4,
    SRC_IO   = 3'd5,
    SRC_ZERO = 3'd6
  } src_e;

  // decoded bank-switch state
  typedef struct packed {
    logic wr_en;   // upper RAM accepts writes
    logic rd_rom;  // upper reads come from ROM
    logic bank1;   // banked window uses the low physical copy
  } map_t;

  localparam map_t MAP_RESET = '{wr_en: 1'b1, rd_rom: 1'b1, bank1: 1'b0};

  function automatic map_t nibble_to_map(input logic [3:0] n);
    map_t m;
    m.wr_en  = n[0];
    m.rd_rom = n[1] ^ n[0];
    m.bank1  = n[3];
    return m;
  endfunction

endpackage

// File: rtl/ubm_mode_reg.sv
module ubm_mode_reg
  import ubm_pkg::*;
#(
  parameter int          AW      = 16,
  parameter logic [15:0] SW_BASE = 16'hC080
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cpu_valid,
  input  logic [AW-1:0] cpu_addr,
  output logic          sw_hit,
  output map_t          map_q
);

  localparam logic [AW-1:0] BASE = AW'(SW_BASE);

  assign sw_hit = (cpu_addr[AW-1:4] == BASE[AW-1:4]);

  always_ff @(posedge clk) begin
    if (rst)
      map_q <= MAP_RESET;
    else if (cpu_valid && sw_hit)
      map_q <= nibble_to_map(cpu_addr[3:0]);
  end

  // R3: mode changes only on a switch-window cycle
  p_mode_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !(cpu_valid && sw_hit) |=> $stable(map_q));

  // R6: address bit 2 never influences the state
  p_bit2_ignored_r6: assert property (@(posedge clk) disable iff (rst)
    (cpu_valid && sw_hit && !cpu_addr[3]) |=> !map_q.bank1);

endmodule

// File: rtl/ubm_decode.sv
module ubm_decode
  import ubm_pkg::*;
#(
  parameter int          AW         = 16,
  parameter int          UROM_AW    = 14,
  parameter int          PER_AW     = 12,
  parameter int          IO_AW      = 8,
  parameter logic [15:0] IO_BASE    = 16'hC000,
  parameter logic [15:0] PER_BASE   = 16'hC100,
  parameter logic [15:0] UPPER_BASE = 16'hD000,
  parameter logic [15:0] BANK_END   = 16'hE000,
  parameter logic [15:0] BANK1_HOME = 16'hC000
) (
  input  logic               cpu_valid,
  input  logic               cpu_we,
  input  logic [AW-1:0]      cpu_addr,
  input  logic               per_sel,
  input  logic               sw_hit,
  input  map_t               map_q,
  output logic               ram_cs,
  output logic               ram_we,
  output logic [AW-1:0]      ram_addr,
  output logic               urom_cs,
  output logic [UROM_AW-1:0] urom_addr,
  output logic [1:0]         per_cs,
  output logic [PER_AW-1:0]  per_addr,
  output logic               io_cs,
  output logic               io_we,
  output logic [IO_AW-1:0]   io_addr,
  output src_e               src
);

  localparam logic [AW-1:0] A_IO    = AW'(IO_BASE);
  localparam logic [AW-1:0] A_PER   = AW'(PER_BASE);
  localparam logic [AW-1:0] A_UP    = AW'(UPPER_BASE);
  localparam logic [AW-1:0] A_BEND  = AW'(BANK_END);
  localparam logic [AW-1:0] BANK_SH = AW'(UPPER_BASE - BANK1_HOME);

  logic [AW-1:0] up_off;
  logic [AW-1:0] phys;

  assign up_off = cpu_addr - A_UP;
  assign phys   = (map_q.bank1 && (cpu_addr < A_BEND)) ? (cpu_addr - BANK_SH)
                                                        : cpu_addr;

  always_comb begin
    ram_cs    = 1'b0;
    ram_we    = 1'b0;
    ram_addr  = cpu_addr;
    urom_cs   = 1'b0;
    urom_addr = up_off[UROM_AW-1:0];
    per_cs    = 2'b00;
    per_addr  = cpu_addr[PER_AW-1:0];
    io_cs     = 1'b0;
    io_we     = 1'b0;
    io_addr   = cpu_addr[IO_AW-1:0];
    src       = SRC_NONE;
    if (cpu_valid) begin
      if (cpu_addr < A_IO) begin
        ram_cs = 1'b1;
        ram_we = cpu_we;
        if (!cpu_we) src = SRC_RAM;
      end else if (cpu_addr < A_PER) begin
        if (sw_hit) begin
          if (!cpu_we) src = SRC_ZERO;
        end else begin
          io_cs = 1'b1;
          io_we = cpu_we;
          if (!cpu_we) src = SRC_IO;
        end
      end else if (cpu_addr < A_UP) begin
        if (!cpu_we) begin
          per_cs[per_sel] = 1'b1;
          src = per_sel ? SRC_PER1 : SRC_PER0;
        end
      end else if (cpu_we) begin
        if (map_q.wr_en) begin
          ram_cs   = 1'b1;
          ram_we   = 1'b1;
          ram_addr = phys;
        end
      end else if (map_q.rd_rom) begin
        urom_cs = 1'b1;
        src     = SRC_UROM;
      end else begin
        ram_cs   = 1'b1;
        ram_addr = phys;
        src      = SRC_RAM;
      end
    end
  end

endmodule

// File: rtl/ubm_rsteer.sv
module ubm_rsteer
  import ubm_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  src_e          src_q,
  input  logic [DW-1:0] ram_rdata,
  input  logic [DW-1:0] urom_rdata,
  input  logic [DW-1:0] per0_rdata,
  input  logic [DW-1:0] per1_rdata,
  input  logic [DW-1:0] io_rdata,
  output logic [DW-1:0] cpu_rdata,
  output logic          cpu_rvalid
);

  src_e          src_d2;
  logic [DW-1:0] pick;

  always_comb begin
    unique case (src_d2)
      SRC_RAM:  pick = ram_rdata;
      SRC_UROM: pick = urom_rdata;
      SRC_PER0: pick = per0_rdata;
      SRC_PER1: pick = per1_rdata;
      SRC_IO:   pick = io_rdata;
      default:  pick = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      src_d2     <= SRC_NONE;
      cpu_rdata  <= '0;
      cpu_rvalid <= 1'b0;
    end else begin
      src_d2     <= src_q;
      cpu_rdata  <= pick;
      cpu_rvalid <= (src_d2 != SRC_NONE);
    end
  end

  // R3: a switch-window read hands back zero
  p_zero_read_r3: assert property (@(posedge clk) disable iff (rst)
    (src_d2 == SRC_ZERO) |=> (cpu_rvalid && cpu_rdata == '0));

endmodule

// File: rtl/upper_bank_mapper.sv
module upper_bank_mapper
  import ubm_pkg::*;
#(
  parameter int          AW         = 16,
  parameter int          DW         = 8,
  parameter int          UROM_AW    = 14,
  parameter int          PER_AW     = 12,
  parameter int          IO_AW      = 8,
  parameter logic [15:0] SW_BASE    = 16'hC080,
  parameter logic [15:0] IO_BASE    = 16'hC000,
  parameter logic [15:0] PER_BASE   = 16'hC100,
  parameter logic [15:0] UPPER_BASE = 16'hD000,
  parameter logic [15:0] BANK_END   = 16'hE000,
  parameter logic [15:0] BANK1_HOME = 16'hC000
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cpu_valid,
  input  logic               cpu_we,
  input  logic [AW-1:0]      cpu_addr,
  input  logic [DW-1:0]      cpu_wdata,
  input  logic               per_sel,
  output logic [DW-1:0]      cpu_rdata,
  output logic               cpu_rvalid,
  output logic               ram_cs,
  output logic               ram_we,
  output logic [AW-1:0]      ram_addr,
  output logic [DW-1:0]      mem_wdata,
  input  logic [DW-1:0]      ram_rdata,
  output logic               urom_cs,
  output logic [UROM_AW-1:0] urom_addr,
  input  logic [DW-1:0]      urom_rdata,
  output logic [1:0]         per_cs,
  output logic [PER_AW-1:0]  per_addr,
  input  logic [DW-1:0]      per0_rdata,
  input  logic [DW-1:0]      per1_rdata,
  output logic               io_cs,
  output logic               io_we,
  output logic [IO_AW-1:0]   io_addr,
  input  logic [DW-1:0]      io_rdata
);

  localparam logic [AW-1:0] A_IO  = AW'(IO_BASE);
  localparam logic [AW-1:0] A_PER = AW'(PER_BASE);
  localparam logic [AW-1:0] A_UP  = AW'(UPPER_BASE);

  logic               sw_hit;
  map_t               map_q;
  logic               d_ram_cs, d_ram_we, d_urom_cs, d_io_cs, d_io_we;
  logic [AW-1:0]      d_ram_addr;
  logic [UROM_AW-1:0] d_urom_addr;
  logic [1:0]         d_per_cs;
  logic [PER_AW-1:0]  d_per_addr;
  logic [IO_AW-1:0]   d_io_addr;
  src_e               d_src;
  src_e               src_q;

  ubm_mode_reg #(.AW(AW), .SW_BASE(SW_BASE)) u_mode (
    .clk(clk), .rst(rst), .cpu_valid(cpu_valid), .cpu_addr(cpu_addr),
    .sw_hit(sw_hit), .map_q(map_q)
  );

  ubm_decode #(
    .AW(AW), .UROM_AW(UROM_AW), .PER_AW(PER_AW), .IO_AW(IO_AW),
    .IO_BASE(IO_BASE), .PER_BASE(PER_BASE), .UPPER_BASE(UPPER_BASE),
    .BANK_END(BANK_END), .BANK1_HOME(BANK1_HOME)
  ) u_dec (
    .cpu_valid(cpu_valid), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .per_sel(per_sel), .sw_hit(sw_hit), .map_q(map_q),
    .ram_cs(d_ram_cs), .ram_we(d_ram_we), .ram_addr(d_ram_addr),
    .urom_cs(d_urom_cs), .urom_addr(d_urom_addr),
    .per_cs(d_per_cs), .per_addr(d_per_addr),
    .io_cs(d_io_cs), .io_we(d_io_we), .io_addr(d_io_addr),
    .src(d_src)
  );

  // registered device side
  always_ff @(posedge clk) begin
    if (rst) begin
      ram_cs  <= 1'b0;
      ram_we  <= 1'b0;
      urom_cs <= 1'b0;
      per_cs  <= 2'b00;
      io_cs   <= 1'b0;
      io_we   <= 1'b0;
      src_q   <= SRC_NONE;
    end else begin
      ram_cs  <= d_ram_cs;
      ram_we  <= d_ram_we;
      urom_cs <= d_urom_cs;
      per_cs  <= d_per_cs;
      io_cs   <= d_io_cs;
      io_we   <= d_io_we;
      src_q   <= d_src;
    end
  end

  always_ff @(posedge clk) begin
    ram_addr  <= d_ram_addr;
    urom_addr <= d_urom_addr;
    per_addr  <= d_per_addr;
    io_addr   <= d_io_addr;
    mem_wdata <= cpu_wdata;
  end

  ubm_rsteer #(.DW(DW)) u_steer (
    .clk(clk), .rst(rst), .src_q(src_q),
    .ram_rdata(ram_rdata), .urom_rdata(urom_rdata),
    .per0_rdata(per0_rdata), .per1_rdata(per1_rdata), .io_rdata(io_rdata),
    .cpu_rdata(cpu_rdata), .cpu_rvalid(cpu_rvalid)
  );

  // R2: at most one device selected at a time
  p_one_target_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ram_cs, urom_cs, per_cs, io_cs}));

  // R1: low range passes straight to RAM
  p_low_direct_r1: assert property (@(posedge clk) disable iff (rst)
    (cpu_valid && cpu_addr < A_IO) |=> (ram_cs && ram_addr == $past(cpu_addr)));

  // R4: read-only upper RAM takes no write
  p_ro_drop_r4: assert property (@(posedge clk) disable iff (rst)
    (cpu_valid && cpu_we && cpu_addr >= A_UP && !map_q.wr_en) |=> !ram_we);

  // R10: peripheral ROM page ignores writes
  p_per_write_r10: assert property (@(posedge clk) disable iff (rst)
    (cpu_valid && cpu_we && cpu_addr >= A_PER && cpu_addr < A_UP)
      |=> !(ram_cs || urom_cs || (|per_cs) || io_cs));

  // R12: a read comes back three edges later
  p_read_latency_r12: assert property (@(posedge clk) disable iff (rst)
    (cpu_valid && !cpu_we) |-> ##3 cpu_rvalid);

endmodule

// File: tb/upper_bank_mapper_tb.sv
module upper_bank_mapper_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_valid = 1'b0;
  logic        cpu_we = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        per_sel = 1'b0;
  logic [7:0]  cpu_rdata;
  logic        cpu_rvalid;
  logic        ram_cs, ram_we, urom_cs, io_cs, io_we;
  logic [15:0] ram_addr;
  logic [7:0]  mem_wdata;
  logic [13:0] urom_addr;
  logic [1:0]  per_cs;
  logic [11:0] per_addr;
  logic [7:0]  io_addr;
  logic [7:0]  ram_q = '0, urom_q = '0, per0_q = '0, per1_q = '0, io_q = '0;

  int unsigned n_vec = 0;
  int unsigned n_bad = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  upper_bank_mapper u_dut (
    .clk(clk), .rst(rst), .cpu_valid(cpu_valid), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .per_sel(per_sel),
    .cpu_rdata(cpu_rdata), .cpu_rvalid(cpu_rvalid),
    .ram_cs(ram_cs), .ram_we(ram_we), .ram_addr(ram_addr),
    .mem_wdata(mem_wdata), .ram_rdata(ram_q),
    .urom_cs(urom_cs), .urom_addr(urom_addr), .urom_rdata(urom_q),
    .per_cs(per_cs), .per_addr(per_addr),
    .per0_rdata(per0_q), .per1_rdata(per1_q),
    .io_cs(io_cs), .io_we(io_we), .io_addr(io_addr), .io_rdata(io_q)
  );

  // ---------------- device models ----------------
  logic [7:0] ram_m [int];
  logic [7:0] exp_m [int];

  function automatic logic [7:0] urom_byte(input logic [13:0] a);
    return a[7:0] ^ {2'b00, a[13:8]} ^ 8'hA5;
  endfunction
  function automatic logic [7:0] per0_byte(input logic [11:0] a);
    return a[7:0] ^ 8'h3C;
  endfunction
  function automatic logic [7:0] per1_byte(input logic [11:0] a);
    return ~a[7:0] ^ {4'h0, a[11:8]};
  endfunction
  function automatic logic [7:0] io_byte(input logic [7:0] a);
    return a ^ 8'hEE;
  endfunction

  function automatic logic [7:0] ram_get(input int k);
    return ram_m.exists(k) ? ram_m[k] : 8'h00;
  endfunction
  function automatic logic [7:0] exp_get(input int k);
    return exp_m.exists(k) ? exp_m[k] : 8'h00;
  endfunction

  always @(posedge clk) begin
    if (ram_cs) begin
      if (ram_we) ram_m[int'(ram_addr)] = mem_wdata;
      else        ram_q <= ram_get(int'(ram_addr));
    end
    if (urom_cs)   urom_q <= urom_byte(urom_addr);
    if (per_cs[0]) per0_q <= per0_byte(per_addr);
    if (per_cs[1]) per1_q <= per1_byte(per_addr);
    if (io_cs && !io_we) io_q <= io_byte(io_addr);
  end

  // ---------------- expected mode model ----------------
  bit e_wr = 1'b1, e_rom = 1'b1, e_b1 = 1'b0;

  function automatic int phys_of(input logic [15:0] a);
    if (e_b1 && a >= 16'hD000 && a < 16'hE000) return int'(a) - 32'h1000;
    return int'(a);
  endfunction

  function automatic logic [7:0] exp_read(input logic [15:0] a);
    if (a < 16'hC000) return exp_get(int'(a));
    if (a >= 16'hC080 && a < 16'hC090) return 8'h00;
    if (a < 16'hC100) return io_byte(a[7:0]);
    if (a < 16'hD000) return per_sel ? per1_byte(a[11:0]) : per0_byte(a[11:0]);
    if (e_rom) return urom_byte(14'(a - 16'hD000));
    return exp_get(phys_of(a));
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic bus(input logic we, input logic [15:0] a, input logic [7:0] d,
                     output logic [7:0] q, output logic v);
    @(negedge clk);
    cpu_valid = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_valid = 1'b0; cpu_we = 1'b0;
    @(negedge clk);
    @(negedge clk);
    q = cpu_rdata; v = cpu_rvalid;
    // expected-model update
    if (a >= 16'hC080 && a < 16'hC090) begin
      e_wr  = a[0];
      e_rom = a[1] ^ a[0];
      e_b1  = a[3];
    end else if (we) begin
      if (a < 16'hC000) exp_m[int'(a)] = d;
      else if (a >= 16'hD000 && e_wr) exp_m[phys_of(a)] = d;
    end
  endtask

  task automatic rd_chk(input logic [15:0] a, input string tag);
    logic [7:0] q; logic v; logic [7:0] e;
    e = exp_read(a);
    bus(1'b0, a, 8'h00, q, v);
    chk(v === 1'b1 && q === e, tag, int'(q), int'(e));
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    logic [7:0] q; logic v;
    bus(1'b1, a, d, q, v);
  endtask

  task automatic phys_chk(input int k, input string tag);
    chk(ram_get(k) === exp_get(k), tag, int'(ram_get(k)), int'(exp_get(k)));
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    chk({ram_cs, urom_cs, per_cs, io_cs, cpu_rvalid} === 6'b0, "R11 selects idle after reset",
        int'({ram_cs, urom_cs, per_cs, io_cs, cpu_rvalid}), 0);
    rd_chk(16'hFFFC, "R11 vector low from ROM");
    rd_chk(16'hFFFD, "R11 vector high from ROM");
  endtask

  task automatic t_low();
    wr(16'h0000, 8'h11);
    wr(16'hBFFF, 8'h22);
    wr(16'h1234, 8'h33);
    phys_chk(32'h0000, "R1 phys 0000");
    phys_chk(32'hBFFF, "R1 phys BFFF");
    rd_chk(16'h0000, "R1 read 0000");
    rd_chk(16'hBFFF, "R1 read BFFF");
    rd_chk(16'h1234, "R1 read 1234");
  endtask

  task automatic t_io();
    rd_chk(16'hC000, "R2 io C000");
    rd_chk(16'hC07F, "R2 io C07F");
    rd_chk(16'hC0F3, "R2 io C0F3");
  endtask

  task automatic t_latency();
    @(negedge clk);
    cpu_valid = 1'b1; cpu_we = 1'b0; cpu_addr = 16'h0040;
    @(negedge clk);
    cpu_valid = 1'b0;
    chk(ram_cs === 1'b1 && ram_addr === 16'h0040, "R12 select one edge later",
        int'(ram_addr), 32'h40);
    @(negedge clk);
    chk(cpu_rvalid === 1'b0, "R12 rvalid not early", int'(cpu_rvalid), 0);
    @(negedge clk);
    chk(cpu_rvalid === 1'b1, "R12 rvalid third edge", int'(cpu_rvalid), 1);
    @(negedge clk);
    wr(16'h0041, 8'h5A);
    chk(cpu_rvalid === 1'b0, "R12 no rvalid on write", int'(cpu_rvalid), 0);
  endtask

  task automatic t_modes();
    for (int m = 0; m < 16; m++) begin
      logic [15:0] sw;
      logic [7:0] q; logic v;
      sw = 16'hC080 + 16'(m);
      bus(m[0] ? 1'b0 : 1'b1, sw, 8'hFF, q, v);
      if (m[0]) chk(v === 1'b1 && q === 8'h00, "R3 switch read is zero", int'(q), 0);
      wr(16'hD123, 8'(m * 16 + 3));
      wr(16'hE456, 8'(m * 16 + 9));
      phys_chk(32'hD123, "R6 R4 phys D123");
      phys_chk(32'hC123, "R6 R4 phys C123");
      phys_chk(32'hE456, "R7 R4 phys E456");
      rd_chk(16'hD123, "R5 R6 read D123");
      rd_chk(16'hE456, "R5 R7 read E456");
    end
  endtask

  task automatic t_rom_offset();
    logic [7:0] q; logic v;
    bus(1'b0, 16'hC089, 8'h00, q, v);   // bank1, ROM read
    rd_chk(16'hD000, "R8 ROM first byte");
    rd_chk(16'hE010, "R8 ROM mid");
    rd_chk(16'hFFFF, "R8 ROM last byte");
  endtask

  task automatic t_shadow();
    logic [7:0] q; logic v;
    bus(1'b1, 16'hC081, 8'h00, q, v);   // bank2, writable, ROM read
    wr(16'hD200, 8'h77);
    phys_chk(32'hD200, "R9 write lands in RAM");
    rd_chk(16'hD200, "R9 read still ROM");
    bus(1'b1, 16'hC083, 8'h00, q, v);   // RAM read
    rd_chk(16'hD200, "R9 RAM holds write");
  endtask

  task automatic t_periph();
    per_sel = 1'b0;
    rd_chk(16'hC100, "R10 per0 C100");
    rd_chk(16'hCFFF, "R10 per0 CFFF");
    per_sel = 1'b1;
    rd_chk(16'hC600, "R10 per1 C600");
    rd_chk(16'hCABC, "R10 per1 CABC");
    wr(16'hC600, 8'h99);
    phys_chk(32'hC600, "R10 write ignored");
    rd_chk(16'hC600, "R10 per1 after write");
    per_sel = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_low();
    t_io();
    t_latency();
    t_modes();
    t_rom_offset();
    t_shadow();
    t_periph();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog R12 actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule